// File: doc/BRIEF.md
# Write-Back Data Cache Tag Array

This block holds the tag and state of a set-associative write-back data cache. It does not hold line data or move anything on the bus. Each entry stores three things:

- a line-aligned tag,
- a valid flag,
- two dirty flags, one for the lower half of the line and one for the upper half.

The surrounding cache controller presents one operation per cycle. Lookups and write hits are answered in the same cycle. Maintenance operations change the state on the next clock edge. The operations are:

- lookup, and write with hit marking;
- line install;
- invalidate by address, by set and way, or of the whole array;
- clean by set and way.

A clean operation produces a write-back request. The request carries the stored line base address and a mask naming the dirty halves. The controller moves the data and then acknowledges the request, which leaves the line clean. During an invalidate-all walk, and while a request waits for its acknowledge, the block reports busy and ignores new operations.

Top module: `cta_tag_array`

## Requirements
- R1: In a non-busy cycle with op lookup (1), write (2) or invalidate-by-address (4), `hit_o` is 1 in that same cycle exactly when some valid way of the set addressed by `addr_i[7:5]` stores `addr_i[31:5]`. The dirty flags play no part in this. `hit_way_o` gives the lowest matching way, and is 0 when there is no hit.
- R2: Op install (3) writes `addr_i[31:5]` into set `addr_i[7:5]`, way `sw_way_i`, marks the entry valid and clears both of its dirty flags.
- R3: A write hit with `wb_mode_i`=1 drives `absorb_o`=1 in that cycle. It sets the upper-half dirty flag when `addr_i[4]`=1 and the lower-half flag when `addr_i[4]`=0.
- R4: A write with `wb_mode_i`=0, or a write that misses, gives `absorb_o`=0 and changes no dirty flag.
- R5: Invalidate-by-address clears only the lowest matching valid way of the addressed set; the other matching ways stay valid.
- R6: Invalidate-by-set-and-way (5) clears the valid flag of entry (`sw_set_i`, `sw_way_i`) without a tag check.
- R7: Clean-by-set-and-way (7) on an entry that is valid and has at least one dirty half raises `wb_req_o` on the next cycle. `wb_base_o` is then the stored tag followed by five zero bits, and `wb_halves_o` has bit 1 for the upper half and bit 0 for the lower half. On an entry that is invalid or has no dirty half, the op raises no request.
- R8: `wb_req_o`, `wb_base_o` and `wb_halves_o` hold steady until a cycle with `wb_ack_i`=1. After that cycle the request drops and both dirty flags of the entry are clear.
- R9: Invalidate-all (6) raises `busy_o` for one cycle per entry (32 cycles at default size), clearing one entry per cycle. When `busy_o` falls, no entry is valid.
- R10: While `busy_o`=1, operations are ignored: `hit_o` and `absorb_o` stay 0 and no entry changes.
- R11: After reset no entry is valid, `busy_o`=0 and `wb_req_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation: 0 none, 1 lookup, 2 write, 3 install, 4 invalidate by address, 5 invalidate by set/way, 6 invalidate all, 7 clean by set/way |
| addr_i | input | 32 | Byte address for lookup, write, install and invalidate by address |
| sw_set_i | input | 3 | Set for set/way operations |
| sw_way_i | input | 2 | Way for set/way operations and install |
| wb_mode_i | input | 1 | 1 selects write-back marking on write hits |
| wb_ack_i | input | 1 | Acknowledge of the pending write-back request |
| busy_o | output | 1 | Walk or write-back pending; operations ignored |
| hit_o | output | 1 | Tag match in the addressed set |
| hit_way_o | output | 2 | Lowest matching way |
| absorb_o | output | 1 | Write hit taken by the cache, no bus write needed |
| wb_req_o | output | 1 | Write-back request pending |
| wb_base_o | output | 32 | Line base address of the request |
| wb_halves_o | output | 2 | Halves to write: bit 1 upper, bit 0 lower |

## Verification
The same line is installed in two ways of one set. Lookups then have to return the lower way, and an invalidate by address has to expose the upper way. This separates first-match priority from last-match priority. Writes are sent to both halves, in both modes, and as hits and misses. Only a hit in write-back mode may change the mask that a later clean reports, which separates the half selection from the mode gating. Cleans go to invalid, clean and dirty entries. One request is held unacknowledged for several cycles while writes are sent to the block, which shows whether ignored operations leak into state. An invalidate-all over a populated array, with lookups issued during the walk, checks the busy length and the final empty state.

// File: rtl/cta_pkg.sv
package cta_pkg;

  typedef logic [31:0] cta_addr_t;

  typedef enum logic [2:0] {
    CTA_NOP      = 3'd0,
    CTA_LOOKUP   = 3'd1,
    CTA_WRITE    = 3'd2,
    CTA_FILL     = 3'd3,
    CTA_INV_ADDR = 3'd4,
    CTA_INV_SW   = 3'd5,
    CTA_INV_ALL  = 3'd6,
    CTA_CLEAN_SW = 3'd7
  } cta_op_e;

  // Half select: the address bit worth half a line.
  function automatic logic cta_half_sel(cta_addr_t a, int unsigned off_w);
    return a[off_w-1];
  endfunction

  // Dirty mask for one half: bit 1 upper, bit 0 lower.
  function automatic logic [1:0] cta_half_mask(logic upper);
    return upper ? 2'b10 : 2'b01;
  endfunction

  // Ops that report the match result.
  function automatic logic cta_reports_hit(cta_op_e o);
    return (o == CTA_LOOKUP) || (o == CTA_WRITE) || (o == CTA_INV_ADDR);
  endfunction

endpackage

// File: rtl/cta_match.sv
module cta_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 27,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [TAG_W-1:0] tags_i [WAYS],
  input  logic [WAYS-1:0]  vals_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] way_o
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = vals_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o = |eq;

  // Lowest matching way wins.
  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/cta_walker.sv
module cta_walker #(
  parameter int ENTRIES = 32,
  localparam int ENT_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             active_o,
  output logic [ENT_W-1:0] idx_o
);
  localparam logic [ENT_W-1:0] LAST = ENT_W'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      idx_o    <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      idx_o    <= '0;
    end else if (active_o) begin
      if (idx_o == LAST) active_o <= 1'b0;
      else               idx_o    <= idx_o + ENT_W'(1);
    end
  end

  AST_WALK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && idx_o != LAST) |=> (active_o && idx_o == $past(idx_o) + ENT_W'(1))); // R9
endmodule

// File: rtl/cta_wb.sv
module cta_wb #(
  parameter int TAG_W = 27,
  parameter int ENT_W = 5,
  localparam int OFF_W = 32 - TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [1:0]       halves_i,
  input  logic [ENT_W-1:0] ent_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [31:0]      base_o,
  output logic [1:0]       halves_o,
  output logic [ENT_W-1:0] ent_o,
  output logic             done_o
);
  assign done_o = req_o && ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o    <= 1'b0;
      base_o   <= '0;
      halves_o <= '0;
      ent_o    <= '0;
    end else if (done_o) begin
      req_o <= 1'b0;
    end else if (launch_i && !req_o) begin
      req_o    <= 1'b1;
      base_o   <= {tag_i, {OFF_W{1'b0}}};
      halves_o <= halves_i;
      ent_o    <= ent_i;
    end
  end

  AST_WB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (halves_o != 2'b00)); // R7
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(base_o) && $stable(halves_o))); // R8
endmodule

// File: rtl/cta_tag_array.sv
module cta_tag_array #(
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 8,
  parameter int WAYS       = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_i,
  input  logic [31:0]      addr_i,
  input  logic [IDX_W-1:0] sw_set_i,
  input  logic [WAY_W-1:0] sw_way_i,
  input  logic             wb_mode_i,
  input  logic             wb_ack_i,
  output logic             busy_o,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic             absorb_o,
  output logic             wb_req_o,
  output logic [31:0]      wb_base_o,
  output logic [1:0]       wb_halves_o
);
  import cta_pkg::*;

  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int TAG_W   = 32 - OFF_W;
  localparam int ENTRIES = SETS * WAYS;
  localparam int ENT_W   = $clog2(ENTRIES);

  // State arrays, entry index = {set, way}
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [ENTRIES-1:0] val_q;
  logic [1:0]         dirty_q [ENTRIES];

  cta_op_e          op;
  logic [IDX_W-1:0] cur_set;
  logic [TAG_W-1:0] cur_tag;
  logic             half;
  logic [TAG_W-1:0] way_tag [WAYS];
  logic [WAYS-1:0]  way_val;
  logic             m_hit;
  logic [WAY_W-1:0] m_way;
  logic [ENT_W-1:0] hit_ent, sw_ent, fill_ent, walk_idx, wb_ent;
  logic             accept, walk_active, walk_start, wb_launch, wb_done;

  assign op       = cta_op_e'(op_i);
  assign cur_set  = addr_i[OFF_W +: IDX_W];
  assign cur_tag  = addr_i[31:OFF_W];
  assign half     = cta_half_sel(addr_i, OFF_W);
  assign hit_ent  = {cur_set, m_way};
  assign sw_ent   = {sw_set_i, sw_way_i};
  assign fill_ent = {cur_set, sw_way_i};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_tag[w] = tag_q[{cur_set, WAY_W'(w)}];
    assign way_val[w] = val_q[{cur_set, WAY_W'(w)}];
  end

  cta_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags_i(way_tag), .vals_i(way_val), .tag_i(cur_tag),
    .hit_o(m_hit), .way_o(m_way)
  );

  assign busy_o     = walk_active || wb_req_o;
  assign accept     = !busy_o;
  assign walk_start = accept && (op == CTA_INV_ALL);
  assign wb_launch  = accept && (op == CTA_CLEAN_SW) && val_q[sw_ent] && (|dirty_q[sw_ent]);

  assign hit_o     = accept && cta_reports_hit(op) && m_hit;
  assign hit_way_o = hit_o ? m_way : '0;
  assign absorb_o  = accept && (op == CTA_WRITE) && m_hit && wb_mode_i;

  cta_walker #(.ENTRIES(ENTRIES)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_i(walk_start),
    .active_o(walk_active), .idx_o(walk_idx)
  );

  cta_wb #(.TAG_W(TAG_W), .ENT_W(ENT_W)) u_wb (
    .clk(clk), .rst_n(rst_n), .launch_i(wb_launch),
    .tag_i(tag_q[sw_ent]), .halves_i(dirty_q[sw_ent]), .ent_i(sw_ent),
    .ack_i(wb_ack_i), .req_o(wb_req_o), .base_o(wb_base_o),
    .halves_o(wb_halves_o), .ent_o(wb_ent), .done_o(wb_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        tag_q[e]   <= '0;
        dirty_q[e] <= '0;
      end
    end else begin
      if (walk_active) val_q[walk_idx] <= 1'b0;
      if (wb_done)     dirty_q[wb_ent] <= 2'b00;
      if (accept) begin
        unique case (op)
          CTA_WRITE: if (absorb_o) dirty_q[hit_ent] <= dirty_q[hit_ent] | cta_half_mask(half);
          CTA_FILL: begin
            tag_q[fill_ent]   <= cur_tag;
            val_q[fill_ent]   <= 1'b1;
            dirty_q[fill_ent] <= 2'b00;
          end
          CTA_INV_ADDR: if (m_hit) val_q[hit_ent] <= 1'b0;
          CTA_INV_SW:   val_q[sw_ent] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == CTA_FILL) |=> val_q[$past(fill_ent)]); // R2
  AST_ABSORB_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    absorb_o |=> ((dirty_q[$past(hit_ent)] & cta_half_mask($past(half))) != 2'b00)); // R3
  AST_INVSW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == CTA_INV_SW) |=> !val_q[$past(sw_ent)]); // R6
  AST_INVALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(walk_active) |-> (val_q == '0)); // R9
endmodule

// File: tb/sim_cta_tag_array.sv
`timescale 1ns/1ps
module sim_cta_tag_array;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] addr = '0;
  logic [2:0]  sw_set = '0;
  logic [1:0]  sw_way = '0;
  logic wb_mode = 1'b0, wb_ack = 1'b0;
  logic busy, hit, absorb, wb_req;
  logic [1:0] hit_way, wb_halves;
  logic [31:0] wb_base;

  always #4 clk = ~clk;

  cta_tag_array u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op), .addr_i(addr), .sw_set_i(sw_set),
    .sw_way_i(sw_way), .wb_mode_i(wb_mode), .wb_ack_i(wb_ack), .busy_o(busy),
    .hit_o(hit), .hit_way_o(hit_way), .absorb_o(absorb), .wb_req_o(wb_req),
    .wb_base_o(wb_base), .wb_halves_o(wb_halves)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Behavioural model
  logic [26:0] m_tag [32];
  bit          m_val [32];
  bit [1:0]    m_dirty [32];
  int          m_walk = 0;
  bit          m_req = 0;
  logic [31:0] m_base = 0;
  bit [1:0]    m_halves = 0;
  int          m_idx = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [23:0] hi, input int s, input logic [4:0] off);
    return {hi, 3'(s), off};
  endfunction

  task automatic step(input logic [2:0] o, input logic [31:0] a, input int s, input int w,
                      input bit md, input bit ak, input string rq);
    bit busy_e, hit_e, abs_e;
    int way_e, si, e;
    logic [26:0] t;
    op = o; addr = a; sw_set = 3'(s); sw_way = 2'(w); wb_mode = md; wb_ack = ak;
    #2;
    busy_e = (m_walk > 0) || m_req;
    si = int'(a[7:5]);
    t = a[31:5];
    hit_e = 0; way_e = 0;
    if (!busy_e && (o == 3'd1 || o == 3'd2 || o == 3'd4)) begin
      for (int k = 0; k < 4; k++)
        if (!hit_e && m_val[si*4+k] && m_tag[si*4+k] == t) begin hit_e = 1; way_e = k; end
    end
    abs_e = hit_e && (o == 3'd2) && md;
    chk(rq, "busy", {31'd0, busy}, {31'd0, busy_e});
    chk(rq, "hit", {31'd0, hit}, {31'd0, hit_e});
    chk(rq, "hit_way", {30'd0, hit_way}, way_e);
    chk(rq, "absorb", {31'd0, absorb}, {31'd0, abs_e});
    chk(rq, "wb_req", {31'd0, wb_req}, {31'd0, m_req});
    if (m_req) begin
      chk(rq, "wb_base", wb_base, m_base);
      chk(rq, "wb_halves", {30'd0, wb_halves}, {30'd0, m_halves});
    end
    // next state
    if (m_walk > 0) begin
      m_val[32 - m_walk] = 0;
      m_walk--;
    end else if (m_req) begin
      if (ak) begin m_dirty[m_idx] = 0; m_req = 0; end
    end else begin
      case (o)
        3'd2: if (abs_e) m_dirty[si*4+way_e] |= (a[4] ? 2'b10 : 2'b01);
        3'd3: begin m_tag[si*4+w] = t; m_val[si*4+w] = 1; m_dirty[si*4+w] = 0; end
        3'd4: if (hit_e) m_val[si*4+way_e] = 0;
        3'd5: m_val[s*4+w] = 0;
        3'd6: m_walk = 32;
        3'd7: begin
          e = s*4 + w;
          if (m_val[e] && m_dirty[e] != 0) begin
            m_req = 1; m_base = {m_tag[e], 5'd0}; m_halves = m_dirty[e]; m_idx = e;
          end
        end
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] A, B, C;
    for (int e = 0; e < 32; e++) begin m_val[e] = 0; m_dirty[e] = 0; m_tag[e] = 0; end
    A = mk(24'h12_3456, 2, 5'h00);
    B = mk(24'h00_ABCD, 2, 5'h00);
    C = mk(24'h77_0001, 2, 5'h00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    step(3'd0, 0, 0, 0, 0, 0, "R11");
    step(3'd1, A, 0, 0, 0, 0, "R11 R1 miss after reset");

    // R2 install, R1 lookup and lowest-way priority
    step(3'd3, A, 0, 1, 0, 0, "R2");
    step(3'd1, A, 0, 0, 0, 0, "R1");
    step(3'd3, A, 0, 3, 0, 0, "R2");
    step(3'd1, A | 32'h1c, 0, 0, 0, 0, "R1 lowest way");
    step(3'd3, B, 0, 0, 0, 0, "R2");
    step(3'd1, B, 0, 0, 0, 0, "R1");
    step(3'd1, C, 0, 0, 0, 0, "R1 miss");

    // R3 write hits, R4 write-through and miss
    step(3'd2, A | 32'h14, 0, 0, 1, 0, "R3 upper");
    step(3'd2, B | 32'h04, 0, 0, 1, 0, "R3 lower");
    step(3'd1, A, 0, 0, 0, 0, "R1 dirty ignored");
    step(3'd2, A | 32'h08, 0, 0, 0, 0, "R4 write-through");
    step(3'd2, C | 32'h10, 0, 0, 1, 0, "R4 miss");

    // R7 clean, R8 hold and ack, R10 ignored while pending
    step(3'd7, 0, 2, 1, 0, 0, "R7 launch");
    step(3'd1, A, 0, 0, 0, 0, "R8 R10 hold");
    step(3'd2, B | 32'h10, 0, 0, 1, 0, "R10 write ignored");
    step(3'd0, 0, 0, 0, 0, 0, "R8 hold");
    step(3'd0, 0, 0, 0, 0, 1, "R8 ack");
    step(3'd7, 0, 2, 1, 0, 0, "R8 clean after ack");
    step(3'd7, 0, 2, 2, 0, 0, "R7 invalid entry");
    step(3'd7, 0, 2, 0, 0, 0, "R7 lower only");
    step(3'd0, 0, 0, 0, 0, 1, "R8 ack");
    step(3'd0, 0, 0, 0, 0, 0, "R8 idle");

    // R5 invalidate by address, R6 by set/way
    step(3'd4, A, 0, 0, 0, 0, "R5");
    step(3'd1, A, 0, 0, 0, 0, "R5 upper way remains");
    step(3'd5, A, 2, 3, 0, 0, "R6");
    step(3'd1, A, 0, 0, 0, 0, "R6 miss");
    step(3'd5, 0, 5, 0, 0, 0, "R6 empty entry");

    // R9 invalidate all, R10 during walk
    for (int s = 0; s < 8; s++) step(3'd3, mk(24'h40_0000 + 24'(s), s, 0), 0, s % 4, 0, 0, "R2 populate");
    step(3'd2, mk(24'h40_0003, 3, 5'h10), 0, 0, 1, 0, "R3 populate");
    step(3'd6, 0, 0, 0, 0, 0, "R9 start");
    for (int c = 0; c < 32; c++) step(3'd1, mk(24'h40_0000 + 24'(c % 8), c % 8, 0), 0, 0, 0, 0, "R9 R10 walk");
    for (int s = 0; s < 8; s++) step(3'd1, mk(24'h40_0000 + 24'(s), s, 0), 0, 0, 0, 0, "R9 empty");
    step(3'd7, 0, 3, 3, 0, 0, "R9 R7 no req on invalid");
    step(3'd0, 0, 0, 0, 0, 0, "R7 idle");

    finish_run();
  end
endmodule